// File: doc/BRIEF.md
# Masked-Write Serial Output Register Bank

This block holds the general-purpose output bits that feed a serialized output frame. It has a number of channels, four by default. Every channel owns 32 stored output bits, split into an upper and a lower 16-bit register. Software updates these registers through a simple word-wide register bus. Each write word carries a 16-bit per-bit write mask in its upper half and 16 new values in its lower half. Only the bits whose mask bit is set take the new value. The mask is used for that one write and is never kept.

Each channel also has three source-enable registers. Together they decide, bit by bit, which inputs drive each position of the channel's 32-bit output frame: an external timer line, an external capture/compare line, or the stored register bit. Enabled sources are ORed together. A frame position with no enabled source is driven low. The serializer that shifts the frame out and the pad logic are outside this block.

Top module: `gpo_frame_bank`

## Requirements
- R1: After reset every stored output bit and every source-enable bit is 0, so every frame bit is 0 and every mapped register reads 0.
- R2: A write to an output register loads data bit k (bus bit k, k = 0..15) into stored bit k only when mask bit k (bus bit 16+k) is 1. Bits whose mask is 0 keep their value.
- R3: The mask is not stored. Reading an output register returns 0 in bus bits 31..16 and the stored bits in bus bits 15..0. A write with an all-zero mask changes nothing.
- R4: The upper output register of a channel drives frame vector bits 31..16, which are frame positions 0..15 counted from the most significant bit. The lower register drives frame vector bits 15..0.
- R5: Channel c (c = 0..3) has its upper output register at byte offset 8c and its lower output register at 8c+4.
- R6: Channel c has its timer-enable, capture-enable and register-enable words at byte offsets 0x20+16c, 0x24+16c and 0x28+16c. All 32 bits of each are written directly and read back unchanged.
- R7: Frame bit b of channel c equals (timer_b AND timer-enable_b) OR (capture_b AND capture-enable_b) OR (stored_b AND register-enable_b). When no enable is set for that bit, the frame bit is 0.
- R8: Accesses to unmapped offsets read 0 and writes to them change nothing. This covers offsets whose two low address bits are not 00, offset 0x2C+16c, and offsets at or above 0x60.
- R9: A write is applied on the rising clock edge while the write enable is high. The frame shows the new value from that edge on and not before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr_i | input | ADDR_W (8) | Byte address of the register access |
| bus_we_i | input | 1 | Write strobe |
| bus_wdata_i | input | 32 | Write word: mask in bits 31..16, values in bits 15..0 for output registers |
| bus_rdata_o | output | 32 | Combinational read data for bus_addr_i |
| tmr_src_i | input | NUM_CH*32 | Timer source lines, channel c in bits 32c+31..32c |
| cap_src_i | input | NUM_CH*32 | Capture/compare source lines, same packing |
| frame_o | output | NUM_CH*32 | Output frames, same packing |

## Verification
Some properties are checked on every cycle. Stored bits outside the mask of the current write never change. Output-register reads always return zeros in the mask half. Unmapped reads return zero. Frame bits with no enabled source stay low. Reset clears the stored bits and the frames.

Other behaviour needs the bench's scenarios and a model of the bank:
- the exact per-bit merge values;
- the address map of each channel and half;
- the OR of overlapping sources;
- the one-edge timing of a write reaching the frame.

// File: rtl/gpo_frame_pkg.sv
package gpo_frame_pkg;

    localparam int WORD_W = 32;
    localparam int HALF_W = 16;
    localparam int SLOT_W = 4;   // words reserved per channel in the enable block

    typedef enum logic [2:0] {
        KIND_NONE,
        KIND_DATA_HI,
        KIND_DATA_LO,
        KIND_SEL_TMR,
        KIND_SEL_CAP,
        KIND_SEL_DAT
    } reg_kind_e;

    // One bus write word for an output register: mask above, values below.
    typedef struct packed {
        logic [HALF_W-1:0] mask;
        logic [HALF_W-1:0] data;
    } mw_word_t;

    function automatic logic [HALF_W-1:0] merge_masked(
        input logic [HALF_W-1:0] held,
        input mw_word_t          w
    );
        return (held & ~w.mask) | (w.data & w.mask);
    endfunction

    function automatic logic [WORD_W-1:0] readback_half(input logic [HALF_W-1:0] q);
        return {{HALF_W{1'b0}}, q};
    endfunction

endpackage

// File: rtl/gpo_addr_decode.sv
module gpo_addr_decode
    import gpo_frame_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 8,
    parameter int CH_W   = 2
) (
    input  logic [ADDR_W-1:0] addr_i,
    output reg_kind_e         kind_o,
    output logic [CH_W-1:0]   ch_o
);
    localparam int WIDX_W = ADDR_W - 2;
    localparam logic [WIDX_W-1:0] DATA_WORDS = WIDX_W'(2 * NUM_CH);
    localparam logic [WIDX_W-1:0] SEL_END    = WIDX_W'(2 * NUM_CH + SLOT_W * NUM_CH);

    logic [WIDX_W-1:0] widx;
    logic [WIDX_W-1:0] soff;
    logic              aligned;

    always_comb begin
        widx    = addr_i[ADDR_W-1:2];
        aligned = (addr_i[1:0] == 2'b00);
        soff    = widx - DATA_WORDS;
        kind_o  = KIND_NONE;
        ch_o    = '0;
        if (aligned) begin
            if (widx < DATA_WORDS) begin
                ch_o   = CH_W'(widx >> 1);
                kind_o = widx[0] ? KIND_DATA_LO : KIND_DATA_HI;
            end else if (widx < SEL_END) begin
                ch_o = CH_W'(soff >> 2);
                case (soff[1:0])
                    2'd0:    kind_o = KIND_SEL_TMR;
                    2'd1:    kind_o = KIND_SEL_CAP;
                    2'd2:    kind_o = KIND_SEL_DAT;
                    default: kind_o = KIND_NONE;
                endcase
            end
        end
    end

endmodule

// File: rtl/gpo_masked_half.sv
module gpo_masked_half
    import gpo_frame_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en_i,
    input  mw_word_t          wr_word_i,
    output logic [HALF_W-1:0] q_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q_o <= '0;
        end else if (wr_en_i) begin
            q_o <= merge_masked(q_o, wr_word_i);
        end
    end

endmodule

// File: rtl/gpo_sel_reg.sv
module gpo_sel_reg #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] q_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q_o <= '0;
        end else if (wr_en_i) begin
            q_o <= wdata_i;
        end
    end

endmodule

// File: rtl/gpo_frame_mux.sv
module gpo_frame_mux #(
    parameter int W = 32
) (
    input  logic [W-1:0] tmr_i,
    input  logic [W-1:0] cap_i,
    input  logic [W-1:0] dat_i,
    input  logic [W-1:0] en_tmr_i,
    input  logic [W-1:0] en_cap_i,
    input  logic [W-1:0] en_dat_i,
    output logic [W-1:0] frame_o
);
    for (genvar b = 0; b < W; b++) begin : g_bit
        assign frame_o[b] = (tmr_i[b] & en_tmr_i[b])
                          | (cap_i[b] & en_cap_i[b])
                          | (dat_i[b] & en_dat_i[b]);
    end

endmodule

// File: rtl/gpo_frame_bank.sv
module gpo_frame_bank
    import gpo_frame_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [ADDR_W-1:0]        bus_addr_i,
    input  logic                     bus_we_i,
    input  logic [WORD_W-1:0]        bus_wdata_i,
    output logic [WORD_W-1:0]        bus_rdata_o,
    input  logic [NUM_CH*WORD_W-1:0] tmr_src_i,
    input  logic [NUM_CH*WORD_W-1:0] cap_src_i,
    output logic [NUM_CH*WORD_W-1:0] frame_o
);
    localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
    localparam int VW   = NUM_CH * WORD_W;

    reg_kind_e       kind;
    logic [CH_W-1:0] ch_idx;
    mw_word_t        wr_word;

    logic [VW-1:0] data_q;
    logic [VW-1:0] sel_tmr_q;
    logic [VW-1:0] sel_cap_q;
    logic [VW-1:0] sel_dat_q;

    assign wr_word = mw_word_t'(bus_wdata_i);

    gpo_addr_decode #(
        .NUM_CH (NUM_CH),
        .ADDR_W (ADDR_W),
        .CH_W   (CH_W)
    ) u_dec (
        .addr_i (bus_addr_i),
        .kind_o (kind),
        .ch_o   (ch_idx)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic hit_ch;
        logic wr_hi, wr_lo, wr_t, wr_c, wr_d;

        assign hit_ch = bus_we_i && (ch_idx == CH_W'(c));
        assign wr_hi  = hit_ch && (kind == KIND_DATA_HI);
        assign wr_lo  = hit_ch && (kind == KIND_DATA_LO);
        assign wr_t   = hit_ch && (kind == KIND_SEL_TMR);
        assign wr_c   = hit_ch && (kind == KIND_SEL_CAP);
        assign wr_d   = hit_ch && (kind == KIND_SEL_DAT);

        gpo_masked_half u_hi (
            .clk       (clk),
            .rst       (rst),
            .wr_en_i   (wr_hi),
            .wr_word_i (wr_word),
            .q_o       (data_q[c*WORD_W+HALF_W +: HALF_W])
        );

        gpo_masked_half u_lo (
            .clk       (clk),
            .rst       (rst),
            .wr_en_i   (wr_lo),
            .wr_word_i (wr_word),
            .q_o       (data_q[c*WORD_W +: HALF_W])
        );

        gpo_sel_reg #(.W(WORD_W)) u_en_tmr (
            .clk     (clk),
            .rst     (rst),
            .wr_en_i (wr_t),
            .wdata_i (bus_wdata_i),
            .q_o     (sel_tmr_q[c*WORD_W +: WORD_W])
        );

        gpo_sel_reg #(.W(WORD_W)) u_en_cap (
            .clk     (clk),
            .rst     (rst),
            .wr_en_i (wr_c),
            .wdata_i (bus_wdata_i),
            .q_o     (sel_cap_q[c*WORD_W +: WORD_W])
        );

        gpo_sel_reg #(.W(WORD_W)) u_en_dat (
            .clk     (clk),
            .rst     (rst),
            .wr_en_i (wr_d),
            .wdata_i (bus_wdata_i),
            .q_o     (sel_dat_q[c*WORD_W +: WORD_W])
        );

        gpo_frame_mux #(.W(WORD_W)) u_mux (
            .tmr_i    (tmr_src_i[c*WORD_W +: WORD_W]),
            .cap_i    (cap_src_i[c*WORD_W +: WORD_W]),
            .dat_i    (data_q[c*WORD_W +: WORD_W]),
            .en_tmr_i (sel_tmr_q[c*WORD_W +: WORD_W]),
            .en_cap_i (sel_cap_q[c*WORD_W +: WORD_W]),
            .en_dat_i (sel_dat_q[c*WORD_W +: WORD_W]),
            .frame_o  (frame_o[c*WORD_W +: WORD_W])
        );
    end

    always_comb begin
        case (kind)
            KIND_DATA_HI: bus_rdata_o = readback_half(data_q[int'(ch_idx)*WORD_W+HALF_W +: HALF_W]);
            KIND_DATA_LO: bus_rdata_o = readback_half(data_q[int'(ch_idx)*WORD_W +: HALF_W]);
            KIND_SEL_TMR: bus_rdata_o = sel_tmr_q[int'(ch_idx)*WORD_W +: WORD_W];
            KIND_SEL_CAP: bus_rdata_o = sel_cap_q[int'(ch_idx)*WORD_W +: WORD_W];
            KIND_SEL_DAT: bus_rdata_o = sel_dat_q[int'(ch_idx)*WORD_W +: WORD_W];
            default:      bus_rdata_o = '0;
        endcase
    end

endmodule

// File: rtl/gpo_frame_bank_chk.sv
module gpo_frame_bank_chk
    import gpo_frame_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 8
) (
    input logic                     clk,
    input logic                     rst,
    input logic [ADDR_W-1:0]        addr,
    input logic                     we,
    input logic [HALF_W-1:0]        wmask,
    input logic [WORD_W-1:0]        rdata,
    input logic [NUM_CH*WORD_W-1:0] frame,
    input logic [NUM_CH*WORD_W-1:0] data_q,
    input logic [NUM_CH*WORD_W-1:0] sel_tmr_q,
    input logic [NUM_CH*WORD_W-1:0] sel_cap_q,
    input logic [NUM_CH*WORD_W-1:0] sel_dat_q
);
    localparam int VW = NUM_CH * WORD_W;

    int         widx;
    logic       aligned, is_data, is_sel;
    logic [VW-1:0] may_change;
    logic [VW-1:0] sel_any;

    always_comb begin
        widx    = int'(addr >> 2);
        aligned = (addr[1:0] == 2'b00);
        is_data = aligned && (widx < 2 * NUM_CH);
        is_sel  = aligned && (widx >= 2 * NUM_CH) && (widx < 6 * NUM_CH)
                  && (((widx - 2 * NUM_CH) % 4) != 3);
        may_change = '0;
        if (we && is_data) begin
            for (int c = 0; c < NUM_CH; c++) begin
                if (widx / 2 == c) begin
                    may_change[c*WORD_W + (((widx % 2) == 0) ? HALF_W : 0) +: HALF_W] = wmask;
                end
            end
        end
        sel_any = sel_tmr_q | sel_cap_q | sel_dat_q;
    end

    p_reset_clears_r1: assert property (@(posedge clk)
        rst |=> (frame == '0 && data_q == '0));

    p_only_masked_change_r2: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((data_q ^ $past(data_q)) & ~$past(may_change)) == '0);

    p_mask_reads_zero_r3: assert property (@(posedge clk) disable iff (rst)
        is_data |-> rdata[WORD_W-1:HALF_W] == '0);

    p_unselected_low_r7: assert property (@(posedge clk) disable iff (rst)
        (frame & ~sel_any) == '0);

    p_unmapped_zero_r8: assert property (@(posedge clk) disable iff (rst)
        (!is_data && !is_sel) |-> rdata == '0);

endmodule

bind gpo_frame_bank gpo_frame_bank_chk #(
    .NUM_CH (NUM_CH),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .addr      (bus_addr_i),
    .we        (bus_we_i),
    .wmask     (bus_wdata_i[31:16]),
    .rdata     (bus_rdata_o),
    .frame     (frame_o),
    .data_q    (data_q),
    .sel_tmr_q (sel_tmr_q),
    .sel_cap_q (sel_cap_q),
    .sel_dat_q (sel_dat_q)
);

// File: tb/gpo_frame_bank_tb.sv
module gpo_frame_bank_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NUM_CH     = 4;
    localparam int ADDR_W     = 8;
    localparam int VW         = NUM_CH * 32;

    logic            clk = 1'b0;
    logic            rst;
    logic [ADDR_W-1:0] addr;
    logic            we;
    logic [31:0]     wdata;
    logic [31:0]     rdata;
    logic [VW-1:0]   tmr, cap, frame;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpo_frame_bank #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_dut (
        .clk         (clk),
        .rst         (rst),
        .bus_addr_i  (addr),
        .bus_we_i    (we),
        .bus_wdata_i (wdata),
        .bus_rdata_o (rdata),
        .tmr_src_i   (tmr),
        .cap_src_i   (cap),
        .frame_o     (frame)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    logic [31:0] m_data [NUM_CH];
    logic [31:0] m_st   [NUM_CH];
    logic [31:0] m_sc   [NUM_CH];
    logic [31:0] m_sd   [NUM_CH];

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_frame(input int c);
        return (tmr[c*32 +: 32] & m_st[c]) | (cap[c*32 +: 32] & m_sc[c])
             | (m_data[c] & m_sd[c]);
    endfunction

    function automatic void model_write(input logic [7:0] a, input logic [31:0] w);
        int wi, o, c;
        if (a[1:0] != 2'b00) return;
        wi = int'(a >> 2);
        if (wi < 2 * NUM_CH) begin
            c = wi / 2;
            if (wi % 2 == 0)
                m_data[c][31:16] = (m_data[c][31:16] & ~w[31:16]) | (w[15:0] & w[31:16]);
            else
                m_data[c][15:0]  = (m_data[c][15:0]  & ~w[31:16]) | (w[15:0] & w[31:16]);
        end else if (wi < 6 * NUM_CH) begin
            o = wi - 2 * NUM_CH;
            c = o / 4;
            case (o % 4)
                0: m_st[c] = w;
                1: m_sc[c] = w;
                2: m_sd[c] = w;
                default: ;
            endcase
        end
    endfunction

    function automatic logic [31:0] exp_read(input logic [7:0] a);
        int wi, o, c;
        if (a[1:0] != 2'b00) return 32'h0;
        wi = int'(a >> 2);
        if (wi < 2 * NUM_CH) begin
            c = wi / 2;
            return (wi % 2 == 0) ? {16'h0, m_data[c][31:16]} : {16'h0, m_data[c][15:0]};
        end else if (wi < 6 * NUM_CH) begin
            o = wi - 2 * NUM_CH;
            c = o / 4;
            case (o % 4)
                0: return m_st[c];
                1: return m_sc[c];
                2: return m_sd[c];
                default: return 32'h0;
            endcase
        end
        return 32'h0;
    endfunction

    task automatic do_write(input logic [7:0] a, input logic [31:0] w);
        @(negedge clk);
        addr = a; wdata = w; we = 1'b1;
        @(posedge clk);
        model_write(a, w);
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic check_read(input string req, input logic [7:0] a);
        @(negedge clk);
        addr = a; we = 1'b0;
        #1;
        check(req, $sformatf("read @%h", a), rdata, exp_read(a));
    endtask

    task automatic check_frames(input string req);
        for (int c = 0; c < NUM_CH; c++)
            check(req, $sformatf("frame ch%0d", c), frame[c*32 +: 32], exp_frame(c));
    endtask

    function automatic logic [7:0] sel_addr(input int c, input int k);
        return 8'(32'h20 + 16 * c + 4 * k);
    endfunction

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] seed_dummy;
        seed_dummy = $urandom(32'h1F2E3D4C);
        rst = 1'b1; we = 1'b0; addr = '0; wdata = '0;
        tmr = '1; cap = '1;
        for (int c = 0; c < NUM_CH; c++) begin
            m_data[c] = '0; m_st[c] = '0; m_sc[c] = '0; m_sd[c] = '0;
        end
        repeat (5) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state with all sources high
        for (int a = 0; a < 32'h60; a += 4) check_read("R1", 8'(a));
        for (int c = 0; c < NUM_CH; c++)
            check("R1", $sformatf("frame ch%0d", c), frame[c*32 +: 32], 32'h0);

        // R9 / R4: enable register bits on ch0, then write upper word
        do_write(sel_addr(0, 2), 32'hFFFF_FFFF);
        @(negedge clk);
        addr = 8'h00; wdata = 32'hFFFF_A5C3; we = 1'b1;
        #1;
        check("R9", "frame before edge", frame[31:0], 32'h0);
        @(posedge clk);
        model_write(8'h00, 32'hFFFF_A5C3);
        @(negedge clk);
        we = 1'b0;
        check("R9", "frame after edge", frame[31:0], 32'hA5C3_0000);
        check("R4", "upper word position", frame[31:0], 32'hA5C3_0000);

        // R2: partial mask
        do_write(8'h00, 32'h00F0_0F0F);
        check("R2", "partial mask merge", frame[31:0], 32'hA503_0000);

        // R3: mask not stored, zero mask holds
        check_read("R3", 8'h00);
        check("R3", "mask half reads zero", rdata, 32'h0000_A503);
        do_write(8'h00, 32'h0000_FFFF);
        check("R3", "zero mask holds", frame[31:0], 32'hA503_0000);

        // R4: lower word
        do_write(8'h04, 32'hFFFF_1234);
        check("R4", "lower word position", frame[31:0], 32'hA503_1234);

        // R5: channel 3 upper register at 0x18
        do_write(sel_addr(3, 2), 32'hFFFF_FFFF);
        do_write(8'h18, 32'hFFFF_BEEF);
        check("R5", "ch3 frame", frame[127:96], 32'hBEEF_0000);
        check("R5", "ch1 untouched", frame[63:32], 32'h0);
        check("R5", "ch2 untouched", frame[95:64], 32'h0);

        // R6: enable register readback
        do_write(sel_addr(1, 1), 32'h1234_5678);
        check_read("R6", sel_addr(1, 1));
        check("R6", "cap enable ch1", rdata, 32'h1234_5678);
        check_read("R6", sel_addr(1, 0));

        // R7: overlapping sources ORed
        @(negedge clk);
        tmr[63:32] = 32'hF0F0_F0F0;
        cap[63:32] = 32'hFF00_FF00;
        do_write(sel_addr(1, 0), 32'h0000_FFFF);
        do_write(sel_addr(1, 2), 32'h00FF_00FF);
        do_write(8'h08, 32'hFFFF_8001);
        check("R7", "ORed sources ch1", frame[63:32], 32'h1201_F6F0);
        check_frames("R7");

        // R8: unmapped writes and reads
        do_write(8'h5C, 32'hFFFF_FFFF);
        do_write(8'h02, 32'hFFFF_FFFF);
        do_write(8'h60, 32'hFFFF_FFFF);
        do_write(8'hFC, 32'hFFFF_FFFF);
        check_frames("R8");
        check_read("R8", 8'h5C);
        check_read("R8", 8'h02);
        check_read("R8", 8'h60);
        check_read("R8", 8'h00);
        check_read("R8", 8'h04);

        // Random phase: R2 R6 R7 R8
        for (int i = 0; i < 400; i++) begin
            logic [7:0] a;
            int r;
            @(negedge clk);
            tmr = {$urandom, $urandom, $urandom, $urandom};
            cap = {$urandom, $urandom, $urandom, $urandom};
            r = int'($urandom % 10);
            if (r < 5)      a = 8'(($urandom % 8) * 4);
            else if (r < 9) a = sel_addr(int'($urandom % 4), int'($urandom % 3));
            else            a = 8'($urandom);
            do_write(a, $urandom);
            check_frames("R2");
            check_read("R6", 8'($urandom % 8'h64));
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule